// File: doc/BRIEF.md
# Dual-Strobe Multiplexed Bus Slave

This block sits on an 8-bit multiplexed address/data bus and answers for two address spaces. The first is a 64-byte clock register space. Its address is latched by a positive address pulse, and it is read and written with active-low read and write strobes under an active-low chip select. The second is a 4096-byte memory. Its 12-bit address is put together from two rising-edge strobes: one carries the low byte and the other the upper four bits. The memory has its own active-low output enable and write enable.

The lower fourteen bytes of the clock space (0x00–0x0D) belong to an external timekeeping core. The block reaches them through a register-file port that carries an address, a write pulse, write data and read data. Bytes 0x0E–0x3F are fifty general-purpose bytes held inside the block.

A power-good input gates every access. While it is low, nothing is written and the bus is never driven. All bus pins are oversampled by a free-running system clock. Each edge is found by comparing two registered copies of a pin.

Top module: `muxbus_slave`

## Requirements
- R1: On the falling edge of `clkAddrStb`, the clock-space address is latched from `busIn`, keeping bits 5:0 (the address is taken modulo 64).
- R2: A rising edge of `memStbLo` latches `busIn[7:0]` as memory address bits 7:0. A rising edge of `memStbHi` latches `busIn[3:0]` as memory address bits 11:8. Each strobe changes only its own part of the address.
- R3: When `clkCsN` is high, a clock-space cycle still latches its address, but it neither drives the bus nor writes anything.
- R4: `busOe` is 1 only while `clkRdN` and `clkCsN` are both low, or while `memOeN` is low. `busOut` then carries the byte at the latched address of that space. If both reads are active at once, the clock space wins. Out of reset, `busOe` is 0.
- R5: A write takes the byte present on `busIn` when the write strobe (`clkWrN` or `memWeN`) returns high. A clock-space write also needs `clkCsN` low at that moment.
- R6: Addresses 0x0C and 0x0D are read-only: a write to either gives no `coreWe` pulse, so a later read returns the core's unchanged value.
- R7: On writes to 0x00 and 0x0A, bit 7 keeps its current value from `coreRdata`. Bits 6:0 take the written data.
- R8: While `supplyOk` is 0, no write in either space changes anything and `busOe` stays 0.
- R9: Addresses 0x0E–0x3F read and write internal storage. For addresses 0x00–0x0D, `coreAddr` equals address bits 3:0, and each write there gives a one-cycle `coreWe` pulse with `coreWdata`.
- R10: The memory stores 4096 separate bytes, addressed by the full 12-bit address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rstN | input | 1 | Active-low synchronous reset of the sampling logic |
| busIn | input | 8 | Bus value seen at the pins |
| busOut | output | 8 | Read data to the bus |
| busOe | output | 1 | Bus output enable (tri-state control) |
| clkAddrStb | input | 1 | Clock-space address pulse, latch on fall |
| clkCsN | input | 1 | Clock-space chip select, active low |
| clkRdN | input | 1 | Clock-space read strobe, active low |
| clkWrN | input | 1 | Clock-space write strobe, active low |
| memStbLo | input | 1 | Memory low-address strobe, latch on rise |
| memStbHi | input | 1 | Memory high-address strobe, latch on rise |
| memOeN | input | 1 | Memory output enable, active low |
| memWeN | input | 1 | Memory write enable, active low |
| supplyOk | input | 1 | Supply valid; low inhibits all access |
| coreAddr | output | 4 | Register-file address to the clock core |
| coreWe | output | 1 | Register-file write pulse |
| coreWdata | output | 8 | Register-file write data |
| coreRdata | input | 8 | Register-file read data from the core |

## Verification
The hardest case to reach is an address that was latched in a cycle with the chip deselected. The latch shows only in a later selected read that has no address phase of its own. To reach it, the bench runs a deselected address-and-write cycle and then raises read and chip select alone, so the returned byte shows which address the block holds. Bit-7 preservation on 0x00 and 0x0A is reached by loading a 1 into bit 7 of the bench's model of the core. The bench then writes a 0 there and checks that the 1 comes back on read.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

  typedef struct packed {
    logic clkAddrLatch;
    logic memLoLatch;
    logic memHiLatch;
    logic clkWrite;
    logic memWrite;
    logic clkRead;
    logic memRead;
  } ctlStrobes_t;

endpackage

// File: rtl/muxbus_ctl.sv
module muxbus_ctl
  import muxbus_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [BUS_W-1:0] busIn,
  input  logic             clkAddrStb,
  input  logic             clkCsN,
  input  logic             clkRdN,
  input  logic             clkWrN,
  input  logic             memStbLo,
  input  logic             memStbHi,
  input  logic             memOeN,
  input  logic             memWeN,
  input  logic             supplyOk,
  output ctlStrobes_t      strb,
  output logic [BUS_W-1:0] sampledBus,
  output logic             busOe
);

  // first registered copy of the pins
  logic sAle, sCsN, sRdN, sWrN, sLo, sHi, sOeN, sWeN, sSup;
  // second copy for edge detection
  logic pAle, pWrN, pLo, pHi, pWeN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sAle <= 1'b0; sCsN <= 1'b1; sRdN <= 1'b1; sWrN <= 1'b1;
      sLo  <= 1'b0; sHi  <= 1'b0; sOeN <= 1'b1; sWeN <= 1'b1;
      sSup <= 1'b0;
      pAle <= 1'b0; pWrN <= 1'b1; pLo <= 1'b0; pHi <= 1'b0; pWeN <= 1'b1;
      sampledBus <= '0;
    end else begin
      sAle <= clkAddrStb; sCsN <= clkCsN; sRdN <= clkRdN; sWrN <= clkWrN;
      sLo  <= memStbLo;   sHi  <= memStbHi; sOeN <= memOeN; sWeN <= memWeN;
      sSup <= supplyOk;
      pAle <= sAle; pWrN <= sWrN; pLo <= sLo; pHi <= sHi; pWeN <= sWeN;
      sampledBus <= busIn;
    end
  end

  always_comb begin
    strb.clkAddrLatch = pAle & ~sAle;
    strb.memLoLatch   = ~pLo & sLo;
    strb.memHiLatch   = ~pHi & sHi;
    strb.clkWrite     = ~pWrN & sWrN & ~sCsN & sSup;
    strb.memWrite     = ~pWeN & sWeN & sSup;
    strb.clkRead      = ~sRdN & ~sCsN & sSup;
    strb.memRead      = ~sOeN & sSup & ~strb.clkRead;
  end

  assign busOe = strb.clkRead | strb.memRead;

  // R3: a clock-space write needs chip select on the sampled pins
  assert_cs_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.clkWrite |-> $past(!clkCsN));

  // R4: bus is driven only for an active read strobe with supply present
  assert_oe_source_R4: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> $past(((!clkRdN && !clkCsN) || !memOeN) && supplyOk));

  // R8: no write of either space without supply
  assert_write_supply_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clkWrite || strb.memWrite) |-> $past(supplyOk));

endmodule

// File: rtl/muxbus_dp.sv
module muxbus_dp
  import muxbus_pkg::*;
#(
  parameter int BUS_W      = 8,
  parameter int CLK_SPACE  = 64,
  parameter int CORE_REGS  = 14,
  parameter int RO_REGS    = 2,
  parameter int RO_BIT_A   = 0,
  parameter int RO_BIT_B   = 10,
  parameter int MEM_LO_W   = 8,
  parameter int MEM_HI_W   = 4,
  localparam int CLK_AW    = $clog2(CLK_SPACE),
  localparam int CORE_AW   = $clog2(CORE_REGS),
  localparam int USER_CNT  = CLK_SPACE - CORE_REGS,
  localparam int MEM_AW    = MEM_LO_W + MEM_HI_W,
  localparam int MEM_DEPTH = 1 << MEM_AW
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strb,
  input  logic [BUS_W-1:0]   sampledBus,
  output logic [BUS_W-1:0]   busOut,
  output logic [CORE_AW-1:0] coreAddr,
  output logic               coreWe,
  output logic [BUS_W-1:0]   coreWdata,
  input  logic [BUS_W-1:0]   coreRdata
);

  localparam logic [CLK_AW-1:0] USER_BASE = CLK_AW'(CORE_REGS);
  localparam logic [CLK_AW-1:0] RO_FIRST  = CLK_AW'(CORE_REGS - RO_REGS);
  localparam logic [CLK_AW-1:0] BIT_A     = CLK_AW'(RO_BIT_A);
  localparam logic [CLK_AW-1:0] BIT_B     = CLK_AW'(RO_BIT_B);

  logic [CLK_AW-1:0]   clkAddr;
  logic [MEM_LO_W-1:0] memLo;
  logic [MEM_HI_W-1:0] memHi;
  logic [MEM_AW-1:0]   memAddr;
  logic [CLK_AW-1:0]   userIdx;
  logic                isUser;
  logic [BUS_W-1:0]    userRam [USER_CNT];
  logic [BUS_W-1:0]    memArr  [MEM_DEPTH];
  logic [BUS_W-1:0]    clkData;

  // address latches
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkAddr <= '0;
      memLo   <= '0;
      memHi   <= '0;
    end else begin
      if (strb.clkAddrLatch) clkAddr <= sampledBus[CLK_AW-1:0];
      if (strb.memLoLatch)   memLo   <= sampledBus[MEM_LO_W-1:0];
      if (strb.memHiLatch)   memHi   <= sampledBus[MEM_HI_W-1:0];
    end
  end

  assign memAddr  = {memHi, memLo};
  assign isUser   = (clkAddr >= USER_BASE);
  assign userIdx  = clkAddr - USER_BASE;
  assign coreAddr = clkAddr[CORE_AW-1:0];

  // storage writes; arrays model retained contents and take no reset
  always_ff @(posedge clk) begin
    if (strb.clkWrite && isUser) userRam[userIdx] <= sampledBus;
    if (strb.memWrite)           memArr[memAddr]  <= sampledBus;
  end

  // write path to the core with read-only masking
  always_comb begin
    coreWe    = strb.clkWrite && (clkAddr < RO_FIRST);
    coreWdata = sampledBus;
    if (clkAddr == BIT_A || clkAddr == BIT_B)
      coreWdata = {coreRdata[BUS_W-1], sampledBus[BUS_W-2:0]};
  end

  assign clkData = isUser ? userRam[userIdx] : coreRdata;
  assign busOut  = strb.clkRead ? clkData : memArr[memAddr];

  // R6: the two top core registers never see a write
  assert_ro_regs_R6: assert property (@(posedge clk) disable iff (!rstN)
    coreWe |-> (coreAddr < CORE_AW'(CORE_REGS - RO_REGS)));

  // R7: bit 7 of the two protected registers follows the core's value
  assert_bit7_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (coreWe && (coreAddr == CORE_AW'(RO_BIT_A) || coreAddr == CORE_AW'(RO_BIT_B)))
      |-> (coreWdata[BUS_W-1] == coreRdata[BUS_W-1]));

endmodule

// File: rtl/muxbus_slave.sv
module muxbus_slave
  import muxbus_pkg::*;
#(
  parameter int BUS_W     = 8,
  parameter int CLK_SPACE = 64,
  parameter int CORE_REGS = 14,
  parameter int MEM_LO_W  = 8,
  parameter int MEM_HI_W  = 4,
  localparam int CORE_AW  = $clog2(CORE_REGS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [BUS_W-1:0]   busIn,
  output logic [BUS_W-1:0]   busOut,
  output logic               busOe,
  input  logic               clkAddrStb,
  input  logic               clkCsN,
  input  logic               clkRdN,
  input  logic               clkWrN,
  input  logic               memStbLo,
  input  logic               memStbHi,
  input  logic               memOeN,
  input  logic               memWeN,
  input  logic               supplyOk,
  output logic [CORE_AW-1:0] coreAddr,
  output logic               coreWe,
  output logic [BUS_W-1:0]   coreWdata,
  input  logic [BUS_W-1:0]   coreRdata
);

  ctlStrobes_t      strb;
  logic [BUS_W-1:0] sampledBus;

  muxbus_ctl #(.BUS_W(BUS_W)) ctl_i (
    .clk(clk), .rstN(rstN), .busIn(busIn),
    .clkAddrStb(clkAddrStb), .clkCsN(clkCsN), .clkRdN(clkRdN), .clkWrN(clkWrN),
    .memStbLo(memStbLo), .memStbHi(memStbHi), .memOeN(memOeN), .memWeN(memWeN),
    .supplyOk(supplyOk), .strb(strb), .sampledBus(sampledBus), .busOe(busOe)
  );

  muxbus_dp #(
    .BUS_W(BUS_W), .CLK_SPACE(CLK_SPACE), .CORE_REGS(CORE_REGS),
    .MEM_LO_W(MEM_LO_W), .MEM_HI_W(MEM_HI_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .sampledBus(sampledBus),
    .busOut(busOut), .coreAddr(coreAddr), .coreWe(coreWe),
    .coreWdata(coreWdata), .coreRdata(coreRdata)
  );

endmodule

// File: tb/muxbus_slave_tb_top.sv
module muxbus_slave_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] busIn;
  logic [7:0] busOut;
  logic       busOe;
  logic       clkAddrStb, clkCsN, clkRdN, clkWrN;
  logic       memStbLo, memStbHi, memOeN, memWeN, supplyOk;
  logic [3:0] coreAddr;
  logic       coreWe;
  logic [7:0] coreWdata, coreRdata;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [7:0] coreMem [14];

  always #5 clk = ~clk;

  muxbus_slave dut_i (
    .clk(clk), .rstN(rstN), .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .clkAddrStb(clkAddrStb), .clkCsN(clkCsN), .clkRdN(clkRdN), .clkWrN(clkWrN),
    .memStbLo(memStbLo), .memStbHi(memStbHi), .memOeN(memOeN), .memWeN(memWeN),
    .supplyOk(supplyOk), .coreAddr(coreAddr), .coreWe(coreWe),
    .coreWdata(coreWdata), .coreRdata(coreRdata)
  );

  // behavioural clock core register file
  assign coreRdata = (coreAddr < 4'd14) ? coreMem[coreAddr] : 8'h00;
  always @(posedge clk) if (coreWe && coreAddr < 4'd14) coreMem[coreAddr] <= coreWdata;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      failures++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clkAddrPhase(input logic [7:0] a);
    busIn = a; clkAddrStb = 1'b1; waitN(2);
    clkAddrStb = 1'b0; waitN(2);
  endtask

  task automatic clkWrite(input logic [7:0] a, input logic [7:0] d, input bit sel);
    clkAddrPhase(a);
    clkCsN = !sel; busIn = d; clkWrN = 1'b0; waitN(3);
    clkWrN = 1'b1; waitN(3);
    clkCsN = 1'b1; waitN(1);
  endtask

  task automatic clkReadData(input bit sel, output logic oe, output logic [7:0] d);
    clkCsN = !sel; clkRdN = 1'b0; waitN(3);
    oe = busOe; d = busOut;
    clkRdN = 1'b1; clkCsN = 1'b1; waitN(3);
  endtask

  task automatic clkRead(input logic [7:0] a, input bit sel, output logic oe, output logic [7:0] d);
    clkAddrPhase(a);
    clkReadData(sel, oe, d);
  endtask

  task automatic memAddrPhase(input logic [11:0] a);
    busIn = a[7:0]; memStbLo = 1'b1; waitN(2); memStbLo = 1'b0; waitN(1);
    busIn = {4'h0, a[11:8]}; memStbHi = 1'b1; waitN(2); memStbHi = 1'b0; waitN(1);
  endtask

  task automatic memWrite(input logic [11:0] a, input logic [7:0] d);
    memAddrPhase(a);
    busIn = d; memWeN = 1'b0; waitN(3); memWeN = 1'b1; waitN(3);
  endtask

  task automatic memRead(input logic [11:0] a, output logic oe, output logic [7:0] d);
    memAddrPhase(a);
    memOeN = 1'b0; waitN(3);
    oe = busOe; d = busOut;
    memOeN = 1'b1; waitN(3);
  endtask

  // {space(1: memory), addr[11:0], write data, expected read}
  localparam int NVEC = 12;
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b0, 12'h00E, 8'h5A, 8'h5A},   // R9 first user byte
    {1'b0, 12'h03F, 8'hC3, 8'hC3},   // R9 last user byte
    {1'b0, 12'h002, 8'h17, 8'h17},   // R9 core byte
    {1'b0, 12'h00B, 8'h80, 8'h80},   // R9 core byte, bit 7 writable
    {1'b0, 12'h000, 8'hFF, 8'h7F},   // R7 bit 7 kept at 0
    {1'b0, 12'h00A, 8'hA5, 8'h25},   // R7 bit 7 kept at 0
    {1'b0, 12'h00C, 8'h66, 8'h00},   // R6 read-only
    {1'b0, 12'h00D, 8'h99, 8'h00},   // R6 read-only
    {1'b1, 12'h000, 8'h11, 8'h11},   // R10
    {1'b1, 12'hFFF, 8'hEE, 8'hEE},   // R10 R2
    {1'b1, 12'h5A3, 8'h42, 8'h42},   // R2
    {1'b1, 12'hA5C, 8'h24, 8'h24}    // R2
  };

  initial begin
    logic       oe;
    logic [7:0] d;
    for (int i = 0; i < 14; i++) coreMem[i] = 8'h00;
    rstN = 1'b0; busIn = 8'h00; clkAddrStb = 1'b0; clkCsN = 1'b1; clkRdN = 1'b1;
    clkWrN = 1'b1; memStbLo = 1'b0; memStbHi = 1'b0; memOeN = 1'b1; memWeN = 1'b1;
    supplyOk = 1'b1;
    waitN(4);
    check("R4 reset busOe", {7'b0, busOe}, 8'h00);
    check("R9 reset coreWe", {7'b0, coreWe}, 8'h00);
    rstN = 1'b1; waitN(3);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][28]) begin
        memWrite(VEC[i][27:16], VEC[i][15:8]);
        memRead(VEC[i][27:16], oe, d);
      end else begin
        clkWrite(VEC[i][23:16], VEC[i][15:8], 1'b1);
        clkRead(VEC[i][23:16], 1'b1, oe, d);
      end
      check("R4 R5 vector busOe", {7'b0, oe}, 8'h01);
      check("R5 R6 R7 R9 R10 vector data", d, VEC[i][7:0]);
    end

    // R10: earlier locations survive later writes
    memRead(12'h000, oe, d);
    check("R10 mem 0x000 retained", d, 8'h11);

    // R2: high strobe alone changes only the upper bits (0x5A3 -> 0xA5C? no: 0xAA3)
    memWrite(12'hAA3, 8'h3C);
    memAddrPhase(12'h5A3);
    busIn = 8'h0A; memStbHi = 1'b1; waitN(2); memStbHi = 1'b0; waitN(1);
    memOeN = 1'b0; waitN(3); d = busOut; memOeN = 1'b1; waitN(3);
    check("R2 high strobe only", d, 8'h3C);

    // R7: a 1 in bit 7 survives a write of 0
    coreMem[0] = 8'h80;
    clkWrite(8'h00, 8'h05, 1'b1);
    clkRead(8'h00, 1'b1, oe, d);
    check("R7 bit7 kept at 1", d, 8'h85);

    // R1: address taken modulo 64
    clkWrite(8'h60, 8'h3D, 1'b1);
    clkRead(8'h20, 1'b1, oe, d);
    check("R1 address modulo 64", d, 8'h3D);

    // R3: deselected write does nothing, but its address is latched
    clkWrite(8'h21, 8'h10, 1'b1);
    clkWrite(8'h21, 8'h77, 1'b0);
    clkReadData(1'b1, oe, d);
    check("R3 deselected write ignored", d, 8'h10);
    clkWrite(8'h22, 8'h44, 1'b1);
    clkWrite(8'h21, 8'h55, 1'b0);
    clkReadData(1'b1, oe, d);
    check("R3 R1 address latched while deselected", d, 8'h10);
    clkRead(8'h21, 1'b0, oe, d);
    check("R3 deselected read not driven", {7'b0, oe}, 8'h00);

    // R4: clock space wins over memory when both reads are active
    memAddrPhase(12'h000);
    clkAddrPhase(8'h0E);
    memOeN = 1'b0; clkCsN = 1'b0; clkRdN = 1'b0; waitN(3);
    d = busOut; oe = busOe;
    memOeN = 1'b1; clkCsN = 1'b1; clkRdN = 1'b1; waitN(3);
    check("R4 priority data", d, 8'h5A);
    check("R4 released busOe", {7'b0, busOe}, 8'h00);

    // R8: supply low blocks writes and bus drive
    supplyOk = 1'b0; waitN(2);
    memWrite(12'h5A3, 8'h00);
    clkWrite(8'h0E, 8'h00, 1'b1);
    clkWrite(8'h02, 8'h00, 1'b1);
    memRead(12'h5A3, oe, d);
    check("R8 no drive without supply", {7'b0, oe}, 8'h00);
    supplyOk = 1'b1; waitN(2);
    memRead(12'h5A3, oe, d);
    check("R8 memory unchanged", d, 8'h42);
    clkRead(8'h0E, 1'b1, oe, d);
    check("R8 user byte unchanged", d, 8'h5A);
    clkRead(8'h02, 1'b1, oe, d);
    check("R8 core byte unchanged", d, 8'h17);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule